// File: doc/BRIEF.md
# Event Conversion Sequencer with Hit Lockout

This block decides when a multi-channel digitizer takes an event and then fills the channel memory in a fixed-length cycle. A new cycle starts on one of two things: a pulse on the external event input, or a trigger command on the command bus. Function 25 with sub-address 0 writes the selected test word into every channel and skips the converter. Function 25 with sub-address 1 or 2 fires the front-end test pulse at nominal or doubled amplitude, and that cycle stores converted values.

Once a cycle is accepted, a hit flag is set. While it is set, every further event and trigger is ignored. Software clears the flag with function 11 sub-address 3. Function 9 and the init input also clear it. All three clears also abort a cycle that is still running.

The cycle is `CYCLE_CLKS` clocks long and holds one slot of `CYCLE_CLKS/NCH` clocks per channel. At the end of each slot, one write is offered on a valid/ready port in ascending channel order. While ready is low, the write holds with its channel and data unchanged and the slot timer stops, so back-pressure makes the cycle longer.

Top module: `conv_seq`

## Requirements
- R1: After reset, `hit_o`, `busy_o` and `wr_valid_o` are 0 and `amp_sel_o` is 00.
- R2: If `hit_o` is 0, an `event_i` pulse sampled at a clock edge sets `hit_o` and `busy_o` from the next cycle on.
- R3: While `hit_o` is 1, `event_i` has no effect: no new cycle starts and `busy_o` stays 0 once the running cycle has finished.
- R4: A command with function 11 and sub-address 3 clears `hit_o` on the next cycle, and a later event is then accepted again.
- R5: Function 9, and the `cmd_init_i` input, clear both `hit_o` and `busy_o` on the next cycle. A cycle that is in progress makes no further writes.
- R6: With ready held high, channel c is offered during the cycle that follows (c+1)*SLOT edges after acceptance, where SLOT = CYCLE_CLKS/NCH. Channels are offered in ascending order, exactly NCH writes are made, and `busy_o` is high for exactly CYCLE_CLKS cycles.
- R7: In an event cycle, or in a cycle started by function 25 with sub-address 1 or 2, the written data is the channel's converter input slice `adc_data_i[c*DW +: DW]` at the time of the write.
- R8: Function 25 with sub-address 0 writes, to every channel, the `test_pat_i` value captured at acceptance.
- R9: `amp_sel_o` is 01 after an accepted function 25 with sub-address 1, and 10 after one with sub-address 2. It lasts exactly one cycle and is 00 at all other times.
- R10: A function 25 command issued while `hit_o` is 1 is ignored: no amplitude pulse and no new cycle.
- R11: While `wr_valid_o` is 1 and `wr_ready_i` is 0, `wr_valid_o` stays 1 and `wr_chan_o` does not change. The next channel comes SLOT cycles after the write is accepted.
- R12: If a clear arrives in the same cycle as an event, the clear wins and `hit_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| event_i | input | 1 | External event, sampled each edge |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_fn_i | input | 5 | Command function code |
| cmd_addr_i | input | 4 | Command sub-address |
| cmd_init_i | input | 1 | Bus initialize, clears like function 9 |
| adc_data_i | input | NCH*DW | Per-channel converter values, channel c at [c*DW +: DW] |
| test_pat_i | input | DW | Currently selected digital test word |
| wr_valid_o | output | 1 | Channel memory write offered |
| wr_ready_i | input | 1 | Channel memory accepts the write |
| wr_chan_o | output | CW | Channel number of the write |
| wr_data_o | output | DW | Data of the write |
| busy_o | output | 1 | Conversion cycle in progress |
| hit_o | output | 1 | Hit register; 1 locks out new events |
| amp_sel_o | output | 2 | Test-pulse amplitude: 00 none, 01 nominal, 10 double |

## Verification
The bench uses a reduced configuration of four channels and a 16-clock cycle. It checks every cycle of every conversion run against a cycle count worked out from the slot length. A wrong slot count or an off-by-one write offset would show up as a channel offered one cycle early or late. A design that lets events or test triggers through while the flag is set would start a second cycle that the bench sees as `busy_o` rising again. An abort that leaves the timer running would produce stray writes after the clear. When back-pressure is applied, a timer that keeps counting would skip or reorder channels, and a pattern that is not latched at acceptance would write the wrong test word.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  localparam logic [4:0] FN_CLR_MODULE = 5'd9;
  localparam logic [4:0] FN_CLR_HIT    = 5'd11;
  localparam logic [4:0] FN_TRIGGER    = 5'd25;
  localparam logic [3:0] SA_HIT        = 4'd3;

  typedef enum logic [1:0] {
    AMP_NONE = 2'b00,
    AMP_NOM  = 2'b01,
    AMP_DBL  = 2'b10
  } amp_e;

  typedef struct packed {
    logic clear;
    logic trig_test;
    logic trig_nom;
    logic trig_dbl;
  } cmd_dec_t;
endpackage

// File: rtl/conv_cmd_dec.sv
module conv_cmd_dec
  import conv_seq_pkg::*;
(
  input  logic       cmd_valid_i,
  input  logic [4:0] cmd_fn_i,
  input  logic [3:0] cmd_addr_i,
  input  logic       cmd_init_i,
  output cmd_dec_t   dec_o
);
  logic is_trig;

  always_comb begin
    is_trig         = cmd_valid_i && (cmd_fn_i == FN_TRIGGER);
    dec_o.clear     = cmd_init_i ||
                      (cmd_valid_i && (cmd_fn_i == FN_CLR_MODULE)) ||
                      (cmd_valid_i && (cmd_fn_i == FN_CLR_HIT) && (cmd_addr_i == SA_HIT));
    dec_o.trig_test = is_trig && (cmd_addr_i == 4'd0);
    dec_o.trig_nom  = is_trig && (cmd_addr_i == 4'd1);
    dec_o.trig_dbl  = is_trig && (cmd_addr_i == 4'd2);
  end
endmodule

// File: rtl/conv_slot_timer.sv
module conv_slot_timer #(
  parameter int NCH  = 16,
  parameter int SLOT = 45,
  localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int TW  = (SLOT > 1) ? $clog2(SLOT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic          run_i,
  input  logic          ready_i,
  output logic          slot_end_o,
  output logic [CW-1:0] chan_o,
  output logic          last_o
);
  localparam logic [TW-1:0] TICK_LAST = TW'(SLOT - 1);
  localparam logic [CW-1:0] CHAN_LAST = CW'(NCH - 1);

  logic [TW-1:0] tick_q;
  logic [CW-1:0] chan_q;

  assign slot_end_o = run_i && (tick_q == TICK_LAST);
  assign chan_o     = chan_q;
  assign last_o     = slot_end_o && ready_i && (chan_q == CHAN_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      chan_q <= '0;
    end else if (start_i || abort_i) begin
      tick_q <= '0;
      chan_q <= '0;
    end else if (run_i) begin
      if (tick_q == TICK_LAST) begin
        if (ready_i) begin
          tick_q <= '0;
          chan_q <= chan_q + 1'b1;
        end
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/conv_seq.sv
module conv_seq
  import conv_seq_pkg::*;
#(
  parameter int NCH        = 16,
  parameter int DW         = 12,
  parameter int CYCLE_CLKS = 720,
  localparam int CW        = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              event_i,
  input  logic              cmd_valid_i,
  input  logic [4:0]        cmd_fn_i,
  input  logic [3:0]        cmd_addr_i,
  input  logic              cmd_init_i,
  input  logic [NCH*DW-1:0] adc_data_i,
  input  logic [DW-1:0]     test_pat_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [CW-1:0]     wr_chan_o,
  output logic [DW-1:0]     wr_data_o,
  output logic              busy_o,
  output logic              hit_o,
  output logic [1:0]        amp_sel_o
);
  localparam int SLOT = CYCLE_CLKS / NCH;

  cmd_dec_t      dec;
  logic          accept;
  logic          slot_end;
  logic          last;
  logic [CW-1:0] chan;
  logic          hit_q, busy_q, test_q;
  logic [DW-1:0] pat_q;
  amp_e          amp_q;
  logic [DW-1:0] adc_arr [NCH];

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_unpack
      assign adc_arr[g] = adc_data_i[g*DW +: DW];
    end
  endgenerate

  conv_cmd_dec u_dec (
    .cmd_valid_i (cmd_valid_i),
    .cmd_fn_i    (cmd_fn_i),
    .cmd_addr_i  (cmd_addr_i),
    .cmd_init_i  (cmd_init_i),
    .dec_o       (dec)
  );

  assign accept = !hit_q && !dec.clear &&
                  (event_i || dec.trig_test || dec.trig_nom || dec.trig_dbl);

  conv_slot_timer #(.NCH(NCH), .SLOT(SLOT)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (accept),
    .abort_i    (dec.clear),
    .run_i      (busy_q),
    .ready_i    (wr_ready_i),
    .slot_end_o (slot_end),
    .chan_o     (chan),
    .last_o     (last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q  <= 1'b0;
      busy_q <= 1'b0;
      test_q <= 1'b0;
      pat_q  <= '0;
      amp_q  <= AMP_NONE;
    end else begin
      amp_q <= AMP_NONE;
      if (dec.clear) begin
        hit_q  <= 1'b0;
        busy_q <= 1'b0;
      end else if (accept) begin
        hit_q  <= 1'b1;
        busy_q <= 1'b1;
        test_q <= dec.trig_test;
        pat_q  <= test_pat_i;
        if (dec.trig_nom)      amp_q <= AMP_NOM;
        else if (dec.trig_dbl) amp_q <= AMP_DBL;
      end else if (last) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign wr_valid_o = slot_end;
  assign wr_chan_o  = chan;
  assign wr_data_o  = test_q ? pat_q : adc_arr[chan];
  assign busy_o     = busy_q;
  assign hit_o      = hit_q;
  assign amp_sel_o  = amp_q;
endmodule

// File: rtl/conv_seq_chk.sv
module conv_seq_chk #(
  parameter int CW = 4,
  parameter int DW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid_i,
  input logic [4:0]    cmd_fn_i,
  input logic [3:0]    cmd_addr_i,
  input logic          cmd_init_i,
  input logic          wr_valid_o,
  input logic          wr_ready_i,
  input logic [CW-1:0] wr_chan_o,
  input logic [DW-1:0] wr_data_o,
  input logic          busy_o,
  input logic          hit_o,
  input logic [1:0]    amp_sel_o
);
  // busy cannot exist without the lockout flag
  p_busy_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> hit_o);

  // flag set and idle with no command: stays idle
  p_lockout_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && !busy_o && !cmd_valid_i) |=> !busy_o);

  p_clear_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_fn_i == 5'd11 && cmd_addr_i == 4'd3) |=> !hit_o);

  p_clear_mod_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_init_i || (cmd_valid_i && cmd_fn_i == 5'd9)) |=> (!hit_o && !busy_o));

  p_write_in_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> busy_o);

  p_amp_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(amp_sel_o));

  p_amp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (amp_sel_o != 2'b00) |=> (amp_sel_o == 2'b00));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && !wr_ready_i && !cmd_valid_i && !cmd_init_i) |=>
      (wr_valid_o && $stable(wr_chan_o)));
endmodule

bind conv_seq conv_seq_chk #(.CW(CW), .DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid_i (cmd_valid_i),
  .cmd_fn_i    (cmd_fn_i),
  .cmd_addr_i  (cmd_addr_i),
  .cmd_init_i  (cmd_init_i),
  .wr_valid_o  (wr_valid_o),
  .wr_ready_i  (wr_ready_i),
  .wr_chan_o   (wr_chan_o),
  .wr_data_o   (wr_data_o),
  .busy_o      (busy_o),
  .hit_o       (hit_o),
  .amp_sel_o   (amp_sel_o)
);

// File: tb/conv_seq_tb.sv
module conv_seq_tb;
  localparam int NCH   = 4;
  localparam int DW    = 12;
  localparam int CYC   = 16;
  localparam int SLOT  = CYC / NCH;
  localparam int CW    = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              event_i = 1'b0;
  logic              cmd_valid_i = 1'b0;
  logic [4:0]        cmd_fn_i = '0;
  logic [3:0]        cmd_addr_i = '0;
  logic              cmd_init_i = 1'b0;
  logic [NCH*DW-1:0] adc_data_i = '0;
  logic [DW-1:0]     test_pat_i = '0;
  logic              wr_valid_o;
  logic              wr_ready_i = 1'b1;
  logic [CW-1:0]     wr_chan_o;
  logic [DW-1:0]     wr_data_o;
  logic              busy_o, hit_o;
  logic [1:0]        amp_sel_o;

  int vecs = 0;
  int miss = 0;

  always #10 clk = ~clk;

  conv_seq #(.NCH(NCH), .DW(DW), .CYCLE_CLKS(CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .event_i(event_i), .cmd_valid_i(cmd_valid_i),
    .cmd_fn_i(cmd_fn_i), .cmd_addr_i(cmd_addr_i), .cmd_init_i(cmd_init_i),
    .adc_data_i(adc_data_i), .test_pat_i(test_pat_i), .wr_valid_o(wr_valid_o),
    .wr_ready_i(wr_ready_i), .wr_chan_o(wr_chan_o), .wr_data_o(wr_data_o),
    .busy_o(busy_o), .hit_o(hit_o), .amp_sel_o(amp_sel_o)
  );

  function automatic int adc_val(int s, int c);
    return (s * 613 + c * 257 + 5) & 12'hFFF;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      miss++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic load_adc(input int s);
    for (int c = 0; c < NCH; c++) adc_data_i[c*DW +: DW] = DW'(adc_val(s, c));
  endtask

  // issue a command at the current negedge; return at the next negedge
  task automatic do_cmd(input int fn, input int sa);
    cmd_valid_i = 1'b1; cmd_fn_i = 5'(fn); cmd_addr_i = 4'(sa);
    @(negedge clk);
    cmd_valid_i = 1'b0;
  endtask

  // kind 0 event, 1..3 trigger sub-address 0..2
  task automatic run_cycle(input int kind, input int s);
    int exp_amp;
    logic [DW-1:0] pat;
    pat = DW'((12'h249 << s) | s);
    test_pat_i = pat;
    load_adc(s);
    exp_amp = (kind == 2) ? 1 : (kind == 3) ? 2 : 0;
    if (kind == 0) event_i = 1'b1;
    else begin cmd_valid_i = 1'b1; cmd_fn_i = 5'd25; cmd_addr_i = 4'(kind - 1); end
    for (int k = 1; k <= CYC + 1; k++) begin
      @(negedge clk);
      if (k == 1) begin
        event_i = 1'b0; cmd_valid_i = 1'b0;
        test_pat_i = ~pat;  // change after capture: R8 needs the latched word
        chk("R2 hit set", int'(hit_o), 1);
        chk("R9 amp pulse", int'(amp_sel_o), exp_amp);
      end else begin
        chk("R9 amp idle", int'(amp_sel_o), 0);
      end
      chk("R6 busy window", int'(busy_o), (k <= CYC) ? 1 : 0);
      chk("R6 write slot", int'(wr_valid_o), ((k % SLOT == 0) && k <= CYC) ? 1 : 0);
      if ((k % SLOT == 0) && k <= CYC) begin
        chk("R6 write order", int'(wr_chan_o), k / SLOT - 1);
        if (kind == 1) chk("R8 test word", int'(wr_data_o), int'(pat));
        else           chk("R7 adc data", int'(wr_data_o), adc_val(s, k / SLOT - 1));
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miss++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 hit reset", int'(hit_o), 0);
    chk("R1 busy reset", int'(busy_o), 0);
    chk("R1 valid reset", int'(wr_valid_o), 0);
    chk("R1 amp reset", int'(amp_sel_o), 0);

    for (int s = 0; s < 4; s++) begin
      for (int kind = 0; kind < 4; kind++) begin
        run_cycle(kind, s);
        // R3 / R10: events and triggers while locked are ignored
        event_i = 1'b1; cmd_valid_i = 1'b1; cmd_fn_i = 5'd25; cmd_addr_i = 4'(kind % 3);
        @(negedge clk);
        event_i = 1'b0; cmd_valid_i = 1'b0;
        chk("R10 no amp when locked", int'(amp_sel_o), 0);
        chk("R3 no restart", int'(busy_o), 0);
        @(negedge clk);
        chk("R3 still idle", int'(busy_o), 0);
        chk("R3 no write", int'(wr_valid_o), 0);
        chk("R3 hit held", int'(hit_o), 1);
        // clears rotate through the three forms
        case ((s + kind) % 3)
          0: begin do_cmd(11, 3); chk("R4 hit clear", int'(hit_o), 0); end
          1: begin do_cmd(9, 0);  chk("R5 f9 clear", int'(hit_o), 0); end
          default: begin
            cmd_init_i = 1'b1; @(negedge clk); cmd_init_i = 1'b0;
            chk("R5 init clear", int'(hit_o), 0);
          end
        endcase
      end
    end

    // R4: non-clear sub-address of function 11 leaves the flag set
    event_i = 1'b1; @(negedge clk); event_i = 1'b0;
    do_cmd(11, 2);
    chk("R4 wrong sub-address", int'(hit_o), 1);
    // R5: abort mid-cycle, no writes afterwards
    do_cmd(9, 0);
    chk("R5 abort hit", int'(hit_o), 0);
    chk("R5 abort busy", int'(busy_o), 0);
    for (int k = 0; k < CYC; k++) begin
      @(negedge clk);
      chk("R5 no stray write", int'(wr_valid_o), 0);
    end

    // R12: clear and event together
    event_i = 1'b1;
    do_cmd(11, 3);
    event_i = 1'b0;
    chk("R12 clear wins hit", int'(hit_o), 0);
    chk("R12 clear wins busy", int'(busy_o), 0);

    // R11: back-pressure on channel 0
    load_adc(7);
    wr_ready_i = 1'b0;
    event_i = 1'b1;
    for (int k = 1; k <= SLOT; k++) begin
      @(negedge clk);
      event_i = 1'b0;
    end
    chk("R11 offered", int'(wr_valid_o), 1);
    for (int w = 0; w < 3; w++) begin
      @(negedge clk);
      chk("R11 held valid", int'(wr_valid_o), 1);
      chk("R11 held chan", int'(wr_chan_o), 0);
      chk("R11 held data", int'(wr_data_o), adc_val(7, 0));
    end
    wr_ready_i = 1'b1;
    for (int k = 1; k <= SLOT; k++) begin
      @(negedge clk);
      chk("R11 next slot timing", int'(wr_valid_o), (k == SLOT) ? 1 : 0);
    end
    chk("R11 next channel", int'(wr_chan_o), 1);
    for (int k = 1; k <= CYC - 2 * SLOT + 1; k++) @(negedge clk);
    chk("R6 cycle stretched end", int'(busy_o), 0);
    do_cmd(11, 3);
    chk("R4 final clear", int'(hit_o), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule